// File: doc/BRIEF.md
# Block-Buffered Pixel Level Shifter

This block takes unsigned pixels one at a time from a serial input, keeping only the cycles on which the input strobe is high. It collects one complete block of samples in an internal buffer. Once the block is full, it makes a separate pass over the buffer and re-centres every stored value on zero. It then streams the results out in arrival order, one per cycle, each marked by an output strobe.

It belongs at the front of a block-transform pipeline that needs signed, zero-centred samples. A block is always stored in full before any work is done on it. While the block is being shifted or sent out, the input is closed. When the last result has gone out, the block is ready to collect the next block at once.

Top module: `blk_level_shift`

## Requirements
- R1: After reset, `out_valid` and `out_sample` are 0, and the first strobed input sample is stored as sample 0 of a block.
- R2: A sample is stored only on a cycle where `in_valid` is high. Cycles with `in_valid` low do not advance the sample position, whatever value `in_pix` holds.
- R3: No result is presented until all 64 samples of a block have been stored. `out_valid` stays low through the 64-cycle shift pass that follows the edge capturing the 64th sample.
- R4: Each result is the 8-bit two's-complement value of the sample minus 128. Pixel 0 gives 0x80, pixel 128 gives 0x00 and pixel 255 gives 0x7F.
- R5: Results leave in the same order in which the samples arrived.
- R6: `out_valid` is high for exactly 64 consecutive cycles per block. The first result appears 65 clock edges after the edge that captured the 64th sample.
- R7: After the 64th result, `out_valid` drops. A block strobed in immediately afterwards is stored from sample 0.
- R8: `in_valid` pulses during the shift pass or while results are being sent out are ignored. They change neither the current block's results nor the next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_pix | input | 8 | Unsigned input pixel |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 8 | Signed, zero-centred result |

## Verification
Every result has a fixed due time. Count from the rising edge that stores the 64th sample. For 64 edges after it, `out_valid` must be low. Result k is due after edge 65+k. The strobe must be low again after edge 129. The bench changes inputs and reads outputs only on falling edges, and counts those falling edges from the capture of the last sample, so each comparison lands in the cycle its requirement names. Idle gaps carrying junk pixel values and junk strobes during the busy phases are added. The block after them checks that nothing leaked in.

// File: rtl/blk_level_shift.sv
module blk_level_shift #(
  parameter int SAMPLE_W  = 8,
  parameter int BLOCK_LEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_pix,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  localparam int IDX_W = $clog2(BLOCK_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);
  localparam logic [SAMPLE_W-1:0] MID = {1'b1, {(SAMPLE_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_CAP = 2'd0, ST_SHIFT = 2'd1, ST_EMIT = 2'd2} st_e;

  st_e                 state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SAMPLE_W-1:0] buf_q [BLOCK_LEN];

  wire at_last = (idx_q == LAST_IDX);
  wire step    = (state_q == ST_CAP) ? in_valid : 1'b1;
  wire [IDX_W-1:0] idx_nx = at_last ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (state_q == ST_CAP && in_valid)
      buf_q[idx_q] <= in_pix;
    else if (state_q == ST_SHIFT)
      buf_q[idx_q] <= buf_q[idx_q] - MID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_CAP;
      idx_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      if (step) idx_q <= idx_nx;
      case (state_q)
        ST_CAP:   if (in_valid && at_last) state_q <= ST_SHIFT;
        ST_SHIFT: if (at_last) state_q <= ST_EMIT;
        ST_EMIT: begin
          out_valid  <= 1'b1;
          out_sample <= buf_q[idx_q];
          if (at_last) state_q <= ST_CAP;
        end
        default:  state_q <= ST_CAP;
      endcase
    end
  end
endmodule

module blk_level_shift_chk #(
  parameter int BLOCK_LEN = 64,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [1:0]       state,
  input logic [IDX_W-1:0] idx
);
  logic [IDX_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else        run_q <= out_valid ? run_q + 1'b1 : '0;

  // R2
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !in_valid) |=> $stable(idx));

  // R3
  early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state) == 2'd2 && $past(idx) == '0);

  // R5
  emit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && idx != IDX_W'(BLOCK_LEN - 1)) |=> idx == $past(idx) + 1'b1);

  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> run_q < (IDX_W + 1)'(BLOCK_LEN));

  // R7
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> state == 2'd0 && idx == '0);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && in_valid) |=> state != 2'd0);
endmodule

bind blk_level_shift blk_level_shift_chk #(.BLOCK_LEN(BLOCK_LEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .state(state_q), .idx(idx_q)
);

// File: tb/blk_level_shift_tb.sv
`timescale 1ns/1ps
module blk_level_shift_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_valid;
  logic [7:0] out_sample;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  blk_level_shift u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] pix_of(input int id, input int k);
    case (id)
      0: return 8'(k * 4);
      1: case (k % 4) 0: return 8'd0; 1: return 8'd255; 2: return 8'd128; default: return 8'd127; endcase
      2: return 8'(255 - k * 3);
      default: return 8'(k * 37 + 11);
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_sample == 8'h00, "R1 out_sample", out_sample, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_block(input int id, input bit gaps, input bit junk);
    logic [7:0] expv [64];
    for (int k = 0; k < 64; k++) begin
      expv[k] = pix_of(id, k);
      @(negedge clk);
      in_valid = 1'b1;
      in_pix = expv[k];
      if (gaps && (k % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;   // R2: idle cycle with junk pixel
        in_pix = 8'hA5;
        chk(out_valid == 1'b0, "R2 no output mid-capture", out_valid, 0);
      end
    end
    @(negedge clk);
    in_valid = junk;       // R8: strobes during shift pass
    in_pix = 8'h3C;
    for (int s = 1; s <= 64; s++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R3 no output before shift done", out_valid, 0);
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      // R4 R5 R6
      chk(out_valid == 1'b1, "R6 out_valid run", out_valid, 1);
      chk(out_sample == 8'(expv[k] - 8'd128), "R4 R5 value/order", out_sample, 8'(expv[k] - 8'd128));
      in_valid = junk && (k < 63);
      in_pix = 8'(k + 200);
    end
    @(negedge clk);
    // R7
    chk(out_valid == 1'b0, "R7 out_valid drops", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_block(0, 1'b0, 1'b0);
    t_block(1, 1'b1, 1'b0);
    t_block(2, 1'b0, 1'b1);
    t_block(3, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule